// File: doc/BRIEF.md
# Exception Priority and Vectoring Unit

This unit decides which control-flow event a 32-bit processor takes in a given cycle. Six sources compete: a filtered reset request, a hardware exception, a non-maskable break, a maskable break, a level-sensitive external interrupt and a user-vector software trap. The unit holds the three machine-status bits that gate these events: interrupt enable, break active and exception active. It also applies the return instructions that clear or restore those bits.

Edge-triggered requests are latched into a pending set. Each cycle the highest-priority eligible source is granted. For the granted event the unit drives a take strobe, a cause code, the handler vector address and the number of the register that receives the return address. The status update for that event lands on the next clock edge. Writing the return address and steering the program counter are done by the surrounding pipeline.

Top module: `exc_vector_unit`

## Requirements
- R1: At most one event is taken per cycle, in fixed priority: reset, hardware exception, non-maskable break, break, interrupt, trap. Ungranted latched requests stay pending until they are granted.
- R2: A reset event is taken only in the 16th consecutive cycle that `rst_req_i` is high, and only once per assertion. A shorter assertion has no effect. While `rst_req_i` is high and the reset event is not firing, no other event is taken, but new requests are still latched. The reset event has vector 0x0 and return register 0. It pulses `clr_spr_o`, discards all pending requests and loads the status bits from `RESET_STAT` at the next edge.
- R3: A hardware exception has vector 0x20 and return register 17. It sets exception-active.
- R4: A non-maskable break or a maskable break has vector 0x18 and return register 16. It sets break-active.
- R5: The interrupt is level-sensitive and is not latched. It is taken only while interrupt-enable is 1 and both break-active and exception-active are 0. It has vector 0x10 and return register 14, and it clears interrupt-enable.
- R6: A trap has vector 0x8 and return register `TRAP_REG` (default 15). It leaves the status bits unchanged.
- R7: At the next edge, `ret_brk_i` clears break-active, `ret_int_i` sets interrupt-enable and `ret_exc_i` clears exception-active. If an event is taken in the same cycle, that event's status update wins.
- R8: `cause_o` is valid while `take_o` is 1, with 0=reset, 1=hardware exception, 2=non-maskable break, 3=break, 4=interrupt, 5=trap. The status outputs are ordered {ie, bip, eip}.
- R9: While `rst_ni` is low, the status bits equal `RESET_STAT` (default all zero), nothing is pending and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Reset request, filtered by duration |
| hw_exc_i | input | 1 | Hardware exception request pulse |
| nm_brk_i | input | 1 | Non-maskable break request pulse |
| brk_i | input | 1 | Maskable break request pulse (hardware or software) |
| irq_i | input | 1 | External interrupt level |
| trap_i | input | 1 | User-vector trap request pulse |
| ret_brk_i | input | 1 | Return-from-break executed |
| ret_int_i | input | 1 | Return-from-interrupt executed |
| ret_exc_i | input | 1 | Return-from-exception executed |
| take_o | output | 1 | An event is taken this cycle |
| cause_o | output | 3 | Code of the taken event |
| vector_o | output | 32 | Handler address of the taken event |
| ret_reg_o | output | 5 | Register number receiving the return address |
| clr_spr_o | output | 1 | Clear the exception, status and FPU special registers |
| ie_o | output | 1 | Interrupt enable |
| bip_o | output | 1 | Break active |
| eip_o | output | 1 | Exception active |

## Verification
Two things can land in the same cycle: a return instruction and the taking of an event that writes the same status bit. The bench provokes this deliberately, for example by issuing a return-from-break while a non-maskable break is being granted. It also does so at random, with return strobes and request pulses drawn independently every cycle. A behavioural model applies the return first and the event's update second, and compares all three status bits after every edge. A second collision is a reset request that matures while other requests are pending. The model expects the reset to win and the pending set to come back empty.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NUM_SRC  = 6;
  localparam int NUM_PEND = 4;
  localparam int ADDR_W   = 32;
  localparam int REG_W    = 5;

  typedef enum logic [2:0] {
    C_RST   = 3'd0,
    C_HWEXC = 3'd1,
    C_NMBRK = 3'd2,
    C_BRK   = 3'd3,
    C_IRQ   = 3'd4,
    C_TRAP  = 3'd5,
    C_NONE  = 3'd7
  } cause_e;

  typedef struct packed {
    logic ie;
    logic bip;
    logic eip;
  } stat_t;

  function automatic logic [ADDR_W-1:0] vec_of(cause_e c);
    case (c)
      C_HWEXC:         vec_of = ADDR_W'(32'h20);
      C_NMBRK, C_BRK:  vec_of = ADDR_W'(32'h18);
      C_IRQ:           vec_of = ADDR_W'(32'h10);
      C_TRAP:          vec_of = ADDR_W'(32'h08);
      default:         vec_of = '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] reg_of(cause_e c, logic [REG_W-1:0] trap_reg);
    case (c)
      C_HWEXC:         reg_of = REG_W'(17);
      C_NMBRK, C_BRK:  reg_of = REG_W'(16);
      C_IRQ:           reg_of = REG_W'(14);
      C_TRAP:          reg_of = trap_reg;
      default:         reg_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/exc_rst_filter.sv
module exc_rst_filter #(
  parameter int MIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic fire_o,
  output logic hold_o
);
  localparam int CW = $clog2(MIN_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign fire_o = req_i && (cnt_q == CW'(MIN_CYC - 1));
  assign hold_o = req_i && !fire_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!req_i)                   cnt_q <= '0;
    else if (cnt_q != CW'(MIN_CYC))    cnt_q <= cnt_q + 1'b1;
  end

  a_r2_fire_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> req_i);
  a_r2_single_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         flush_i,
  output logic [N-1:0] pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (flush_i)  q <= 1'b0;
      else               q <= (q & ~clr_i[i]) | set_i[i];
    end
    assign pend_o[i] = q;

    a_r1_keep_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[i] && !flush_i) |=> q);
  end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N = 6
) (
  input  logic [N-1:0]         req_i,
  output logic [N-1:0]         grant_o,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i] = req_i[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (grant_o[i]) idx_o = ($clog2(N))'(i);
  end

  always_comb a_r1_onehot: assert ($onehot0(grant_o));

endmodule

// File: rtl/exc_status.sv
module exc_status
  import exc_pkg::*;
#(
  parameter stat_t RESET_STAT = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_rst_i,
  input  logic   take_i,
  input  cause_e cause_i,
  input  logic   ret_brk_i,
  input  logic   ret_int_i,
  input  logic   ret_exc_i,
  output stat_t  stat_o
);
  stat_t stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    // returns first, then the taken event overrides
    if (ret_brk_i) stat_d.bip = 1'b0;
    if (ret_int_i) stat_d.ie  = 1'b1;
    if (ret_exc_i) stat_d.eip = 1'b0;
    if (take_i) begin
      case (cause_i)
        C_HWEXC:        stat_d.eip = 1'b1;
        C_NMBRK, C_BRK: stat_d.bip = 1'b1;
        C_IRQ:          stat_d.ie  = 1'b0;
        default:        ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stat_q <= RESET_STAT;
    else if (load_rst_i)  stat_q <= RESET_STAT;
    else                  stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  a_r3_exc_sets_eip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && cause_i == C_HWEXC && !load_rst_i) |=> stat_q.eip);
  a_r4_brk_sets_bip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && (cause_i == C_NMBRK || cause_i == C_BRK) && !load_rst_i) |=> stat_q.bip);
  a_r5_irq_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && cause_i == C_IRQ) |=> !stat_q.ie);
  a_r7_ret_brk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_brk_i && !load_rst_i && !(take_i && (cause_i == C_NMBRK || cause_i == C_BRK)))
      |=> !stat_q.bip);
  a_r6_trap_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && cause_i == C_TRAP && !ret_brk_i && !ret_int_i && !ret_exc_i)
      |=> $stable(stat_q));

endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int          RST_MIN    = 16,
  parameter stat_t       RESET_STAT = '0,
  parameter logic [4:0]  TRAP_REG   = 5'd15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rst_req_i,
  input  logic        hw_exc_i,
  input  logic        nm_brk_i,
  input  logic        brk_i,
  input  logic        irq_i,
  input  logic        trap_i,
  input  logic        ret_brk_i,
  input  logic        ret_int_i,
  input  logic        ret_exc_i,
  output logic        take_o,
  output logic [2:0]  cause_o,
  output logic [31:0] vector_o,
  output logic [4:0]  ret_reg_o,
  output logic        clr_spr_o,
  output logic        ie_o,
  output logic        bip_o,
  output logic        eip_o
);
  localparam int IW = $clog2(NUM_SRC);

  logic                rst_fire, rst_hold;
  logic [NUM_PEND-1:0] pend, pend_set, pend_clr;
  logic [NUM_SRC-1:0]  arb_req, grant;
  logic                any;
  logic [IW-1:0]       idx;
  logic                irq_ok;
  cause_e              cause;
  stat_t               stat;

  exc_rst_filter #(.MIN_CYC(RST_MIN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (rst_req_i),
    .fire_o (rst_fire),
    .hold_o (rst_hold)
  );

  // pending bit order: hw exception, nm break, break, trap
  assign pend_set = {trap_i, brk_i, nm_brk_i, hw_exc_i};
  assign pend_clr = {grant[5], grant[3], grant[2], grant[1]};

  exc_pending #(.N(NUM_PEND)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (pend_set),
    .clr_i   (pend_clr),
    .flush_i (rst_fire),
    .pend_o  (pend)
  );

  assign irq_ok = irq_i && stat.ie && !stat.bip && !stat.eip;

  // index = priority rank, 0 highest
  assign arb_req = {pend[3], irq_ok, pend[2], pend[1], pend[0], 1'b0}
                   & {NUM_SRC{~rst_hold}}
                 | {{(NUM_SRC-1){1'b0}}, rst_fire};

  exc_arbiter #(.N(NUM_SRC)) u_arb (
    .req_i   (arb_req),
    .grant_o (grant),
    .any_o   (any),
    .idx_o   (idx)
  );

  assign cause = any ? cause_e'(idx) : C_NONE;

  exc_status #(.RESET_STAT(RESET_STAT)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_rst_i (rst_fire),
    .take_i     (any),
    .cause_i    (cause),
    .ret_brk_i  (ret_brk_i),
    .ret_int_i  (ret_int_i),
    .ret_exc_i  (ret_exc_i),
    .stat_o     (stat)
  );

  assign take_o    = any;
  assign cause_o   = cause;
  assign vector_o  = vec_of(cause);
  assign ret_reg_o = reg_of(cause, TRAP_REG);
  assign clr_spr_o = rst_fire;
  assign ie_o      = stat.ie;
  assign bip_o     = stat.bip;
  assign eip_o     = stat.eip;

  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && cause_o == 3'(C_IRQ)) |-> (ie_o && !bip_o && !eip_o && irq_i));
  a_r2_hold_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_hold |-> !take_o);
  a_r2_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_spr_o |-> (take_o && cause_o == 3'(C_RST) && vector_o == 32'h0));

endmodule

// File: tb/tb_exc_vector_unit.sv
module tb_exc_vector_unit;
  localparam int RST_MIN = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rst_req, hw, nm, brk, irq, trap, rb, ri, re;
  logic take, clr, ie, bip, eip;
  logic [2:0] cause;
  logic [31:0] vec;
  logic [4:0] rreg;

  int checks = 0, errors = 0;
  bit run = 0;

  // model state
  int m_cnt;
  bit m_p[4];
  bit m_ie, m_bip, m_eip;

  always #2.5 clk = ~clk;

  exc_vector_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req), .hw_exc_i(hw),
    .nm_brk_i(nm), .brk_i(brk), .irq_i(irq), .trap_i(trap),
    .ret_brk_i(rb), .ret_int_i(ri), .ret_exc_i(re),
    .take_o(take), .cause_o(cause), .vector_o(vec), .ret_reg_o(rreg),
    .clr_spr_o(clr), .ie_o(ie), .bip_o(bip), .eip_o(eip)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int c, int npend);
    if (npend > 1) return "R1";
    case (c)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R1";
    endcase
  endfunction

  // compare outputs with model, then advance model by one edge
  task automatic step_model();
    bit fire, hold, ok;
    int c, v, r, np;
    fire = rst_req && (m_cnt == RST_MIN - 1);
    hold = rst_req && !fire;
    ok = irq && m_ie && !m_bip && !m_eip;
    np = m_p[0] + m_p[1] + m_p[2] + m_p[3] + ok;
    if (fire) c = 0;
    else if (hold) c = 7;
    else if (m_p[0]) c = 1;
    else if (m_p[1]) c = 2;
    else if (m_p[2]) c = 3;
    else if (ok) c = 4;
    else if (m_p[3]) c = 5;
    else c = 7;
    case (c)
      1: begin v = 'h20; r = 17; end
      2, 3: begin v = 'h18; r = 16; end
      4: begin v = 'h10; r = 14; end
      5: begin v = 'h08; r = 15; end
      default: begin v = 0; r = 0; end
    endcase
    chk(tag_of(c, np), "take", take, c != 7);
    chk("R2", "clr_spr", clr, fire);
    if (c != 7) begin
      chk({tag_of(c, np), "/R8"}, "cause", cause, c);
      chk(tag_of(c, np), "vector", vec, v);
      chk(tag_of(c, np), "ret_reg", rreg, r);
    end
    chk("R7", "ie", ie, m_ie);
    chk("R7", "bip", bip, m_bip);
    chk("R7", "eip", eip, m_eip);
    // edge
    m_cnt = rst_req ? ((m_cnt == RST_MIN) ? m_cnt : m_cnt + 1) : 0;
    if (fire) begin
      foreach (m_p[i]) m_p[i] = 0;
      m_ie = 0; m_bip = 0; m_eip = 0;
    end else begin
      if (c == 1) m_p[0] = 0;
      if (c == 2) m_p[1] = 0;
      if (c == 3) m_p[2] = 0;
      if (c == 5) m_p[3] = 0;
      if (hw) m_p[0] = 1;
      if (nm) m_p[1] = 1;
      if (brk) m_p[2] = 1;
      if (trap) m_p[3] = 1;
      if (rb) m_bip = 0;
      if (ri) m_ie = 1;
      if (re) m_eip = 0;
      if (c == 1) m_eip = 1;
      if (c == 2 || c == 3) m_bip = 1;
      if (c == 4) m_ie = 0;
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (run) step_model();
  end

  task automatic drive(bit rq, bit h, bit n, bit b, bit iq, bit t,
                       bit xb, bit xi, bit xe, int cyc = 1);
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      rst_req = rq; hw = h; nm = n; brk = b; irq = iq; trap = t;
      rb = xb; ri = xi; re = xe;
    end
  endtask

  task automatic idle(int cyc);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, cyc);
  endtask

  initial begin
    rst_req = 0; hw = 0; nm = 0; brk = 0; irq = 0; trap = 0; rb = 0; ri = 0; re = 0;
    m_cnt = 0; foreach (m_p[i]) m_p[i] = 0;
    m_ie = 0; m_bip = 0; m_eip = 0;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    chk("R9", "take in reset", take, 0);
    chk("R9", "status in reset", {ie, bip, eip}, 0);
    @(negedge clk);
    rst_ni = 1;
    run = 1;
    idle(2);
    // R1: four latched requests at once
    drive(0, 1, 1, 1, 0, 1, 0, 0, 0);
    idle(6);
    drive(0, 0, 0, 0, 0, 0, 1, 1, 1);
    idle(1);
    // R5: interrupt with IE set, then with IE cleared
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 3);
    drive(0, 0, 0, 0, 1, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 2);
    // R5: blocked by bip
    drive(0, 0, 0, 1, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0, 0, 0, 0, 3);
    // R7: return-from-break colliding with a nm break take
    drive(0, 0, 1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 0);
    idle(1);
    drive(0, 0, 0, 0, 0, 0, 1, 0, 1);
    idle(1);
    // R2: glitch of 10 cycles with a trap pending
    drive(1, 0, 0, 0, 0, 1, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 9);
    idle(3);
    // R2: long reset while requests pending
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0);
    drive(1, 1, 0, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 1, 1, 0, 0, 0, 21);
    idle(4);
    // mixed random traffic
    begin
      int rst_left = 0;
      for (int n = 0; n < 3000; n++) begin
        bit rq;
        if (rst_left == 0 && ($urandom % 200) == 0) rst_left = 5 + ($urandom % 20);
        rq = rst_left > 0;
        if (rst_left > 0) rst_left--;
        drive(rq, ($urandom % 12) == 0, ($urandom % 25) == 0, ($urandom % 12) == 0,
              ($urandom % 3) == 0, ($urandom % 10) == 0,
              ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
      end
    end
    idle(3);
    run = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule